// File: doc/BRIEF.md
# Paged Configuration Image Sequencer

The sequencer streams one configuration image out of a word-addressed memory that holds up to eight images, or pages, of different sizes. A small descriptor table holds each page's first word address and its length in words. When a configuration cycle begins, the block latches a 3-bit page number. It looks that page up in the table, jumps straight to the page's first word and reads the page out in address order. Each word goes to a valid/ready output.

A cycle begins only on a rising edge of the output-enable input. The page number is taken at that moment and never again during the cycle. A reconfigure request abandons the current cycle at once. The next cycle waits for a fresh output-enable rise, which also takes a fresh page number. Descriptors are written through a small port that only takes effect while the block is idle. A zero-length descriptor, or one whose page runs past the end of memory, raises an error and produces no reads and no output.

Top module: `cps_page_seq`

## Requirements
- R1: `page_sel` is an unsigned 3-bit number with bit 2 as the most significant bit. Value n selects descriptor n, and value 0 selects the default page 0.
- R2: `page_sel` is captured only when a cycle starts. A change to it later in the cycle has no effect on the words streamed.
- R3: A cycle starts only on an output-enable rise, which is `oe` high in a cycle where it was low in the cycle before. `oe` counts as low during reset. While `oe` stays low, `busy` stays 0 and no read is issued.
- R4: For a valid descriptor (start S, length L), exactly L words are delivered. Word i is the memory content at address S+i, in increasing order.
- R5: The memory returns data one cycle after `mem_rd`. At most one read is outstanding, so a cycle with `mem_rd` high is always followed by one with `mem_rd` low.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R7: `done` is high for exactly one cycle: the cycle right after the last word is accepted. In that cycle `busy` is already 0.
- R8: A descriptor with length 0, or with S+L greater than 2^ADDR_W, sets `error` after lookup with no read and no output word. `error` stays set until the next cycle starts. S+L equal to 2^ADDR_W is valid.
- R9: With `reconfig` high at a clock edge, the next cycle shows `busy` and `out_valid` low. No new cycle starts until `oe` falls and rises again.
- R10: A descriptor write (`desc_we`) takes effect only while `busy` is 0. A write while busy leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe | input | 1 | Output enable; its rising edge starts a cycle |
| reconfig | input | 1 | Abort current cycle and re-arm |
| page_sel | input | 3 | Page number, bit 2 MSB |
| desc_we | input | 1 | Descriptor write strobe |
| desc_idx | input | 3 | Descriptor entry to write |
| desc_start | input | ADDR_W | First word address of the entry |
| desc_len | input | ADDR_W+1 | Length of the entry in words |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, one cycle after `mem_rd` |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted when high with `out_valid` |
| out_data | output | DATA_W | Output word |
| done | output | 1 | One-cycle pulse after the last word is accepted |
| error | output | 1 | Last lookup found a bad descriptor |
| busy | output | 1 | Cycle in progress |

## Verification
The hardest situations to reach from the ports are the ones where the cycle's inputs change while the block is working. These are a page-number change or a descriptor write while streaming is under way, and an abort while `oe` stays high. The bench reaches them by injecting each disturbance at a fixed cycle inside a long page. It then streams the affected page again later and confirms that the original contents come out. It also holds `oe` high after an abort and watches for any restart. Every page is swept under three `out_ready` patterns. Descriptors are placed so that one page ends exactly at the top of memory, one is a single word at the last address, and two are bad in the two different ways.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {
    CPS_IDLE   = 2'd0,
    CPS_LOOK   = 2'd1,
    CPS_STREAM = 2'd2
  } cps_state_e;

  // A page is unusable when empty or when it runs past the last memory word.
  function automatic logic span_bad(input int unsigned first,
                                    input int unsigned count,
                                    input int unsigned words);
    return (count == 0) || ((first + count) > words);
  endfunction

endpackage

// File: rtl/cps_desc_table.sv
module cps_desc_table #(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_allow,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_start,
  input  logic [ADDR_W:0]   wr_len,
  input  logic [SEL_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_start,
  output logic [ADDR_W:0]   rd_len
);
  localparam int ENTRIES = 1 << SEL_W;

  logic [ADDR_W-1:0] start_r [ENTRIES];
  logic [ADDR_W:0]   len_r   [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    wire hit = wr_en && (wr_idx == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        start_r[i] <= '0;
        len_r[i]   <= '0;
      end else if (hit && wr_allow) begin
        start_r[i] <= wr_start;
        len_r[i]   <= wr_len;
      end
    end

    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_allow) |=> ($stable(start_r[i]) && $stable(len_r[i])));
  end

  assign rd_start = start_r[rd_idx];
  assign rd_len   = len_r[rd_idx];
endmodule

// File: rtl/cps_fetch.sv
module cps_fetch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              abort,
  input  logic              active,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W:0]   len,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              last_accept
);
  localparam int LEN_W = ADDR_W + 1;

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  issue_left;
  logic [LEN_W-1:0]  acc_left;
  logic              pend_q;

  wire accept    = out_valid && out_ready;
  wire slot_free = !out_valid || out_ready;
  wire issue     = active && !pend_q && (issue_left != '0) && slot_free;

  assign mem_rd      = issue;
  assign mem_addr    = addr_q;
  assign last_accept = accept && (acc_left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      issue_left <= '0;
      acc_left   <= '0;
      pend_q     <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
    end else if (abort) begin
      issue_left <= '0;
      acc_left   <= '0;
      pend_q     <= 1'b0;
      out_valid  <= 1'b0;
    end else if (load) begin
      addr_q     <= start;
      issue_left <= len;
      acc_left   <= len;
      pend_q     <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        addr_q     <= addr_q + ADDR_W'(1);
        issue_left <= issue_left - LEN_W'(1);
      end
      if (pend_q) begin
        out_data  <= mem_rdata;
        out_valid <= 1'b1;
      end else if (accept) begin
        out_valid <= 1'b0;
      end
      if (accept) acc_left <= acc_left - LEN_W'(1);
    end
  end

  // R5
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !abort) |=> (out_valid && $stable(out_data)));

  // R4
  read_before_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_left <= acc_left);
endmodule

// File: rtl/cps_page_seq.sv
module cps_page_seq
  import cps_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe,
  input  logic              reconfig,
  input  logic [SEL_W-1:0]  page_sel,
  input  logic              desc_we,
  input  logic [SEL_W-1:0]  desc_idx,
  input  logic [ADDR_W-1:0] desc_start,
  input  logic [ADDR_W:0]   desc_len,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              done,
  output logic              error,
  output logic              busy
);
  localparam int unsigned MEM_WORDS = 1 << ADDR_W;

  cps_state_e        state;
  logic              oe_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] look_start;
  logic [ADDR_W:0]   look_len;
  logic              last_accept;

  wire oe_rise   = oe && !oe_q;
  wire start_evt = (state == CPS_IDLE) && oe_rise && !reconfig;
  wire look_bad  = span_bad(32'(look_start), 32'(look_len), MEM_WORDS);
  wire in_look   = (state == CPS_LOOK) && !reconfig;
  wire load_evt  = in_look && !look_bad;
  wire err_evt   = in_look && look_bad;

  assign busy = (state != CPS_IDLE);

  cps_desc_table #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (desc_we),
    .wr_allow (!busy),
    .wr_idx   (desc_idx),
    .wr_start (desc_start),
    .wr_len   (desc_len),
    .rd_idx   (sel_q),
    .rd_start (look_start),
    .rd_len   (look_len)
  );

  cps_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load_evt),
    .abort       (reconfig),
    .active      (state == CPS_STREAM),
    .start       (look_start),
    .len         (look_len),
    .out_ready   (out_ready),
    .mem_rdata   (mem_rdata),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .last_accept (last_accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CPS_IDLE;
      oe_q  <= 1'b0;
      sel_q <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      oe_q <= oe;
      done <= 1'b0;
      if (reconfig) begin
        state <= CPS_IDLE;
      end else begin
        unique case (state)
          CPS_IDLE: if (start_evt) begin
            sel_q <= page_sel;
            error <= 1'b0;
            state <= CPS_LOOK;
          end
          CPS_LOOK: begin
            if (err_evt) begin
              error <= 1'b1;
              state <= CPS_IDLE;
            end else begin
              state <= CPS_STREAM;
            end
          end
          CPS_STREAM: if (last_accept) begin
            done  <= 1'b1;
            state <= CPS_IDLE;
          end
          default: state <= CPS_IDLE;
        endcase
      end
    end
  end

  // R3
  start_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(oe));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  error_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!mem_rd && !out_valid));

  // R9
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig |=> (!busy && !out_valid));
endmodule

// File: tb/sim_cps_page_seq.sv
module sim_cps_page_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 5;
  localparam int DW   = 16;
  localparam int MEMW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe = 1'b0;
  logic reconfig = 1'b0;
  logic [2:0] page_sel = '0;
  logic desc_we = 1'b0;
  logic [2:0] desc_idx = '0;
  logic [AW-1:0] desc_start = '0;
  logic [AW:0] desc_len = '0;
  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic done, error, busy;

  int total = 0;
  int fails = 0;
  int exp_start [8];
  int exp_len [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cps_page_seq #(.ADDR_W(AW), .DATA_W(DW), .SEL_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .oe(oe), .reconfig(reconfig), .page_sel(page_sel),
    .desc_we(desc_we), .desc_idx(desc_idx), .desc_start(desc_start), .desc_len(desc_len),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .error(error), .busy(busy)
  );

  function automatic logic [DW-1:0] word_of(input int a);
    return DW'((a * 97) ^ 32'hC300);
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= word_of(int'(mem_addr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_desc(input int idx, input int st, input int ln, input bit track);
    @(negedge clk);
    desc_we = 1'b1; desc_idx = 3'(idx); desc_start = AW'(st); desc_len = (AW+1)'(ln);
    @(negedge clk);
    desc_we = 1'b0;
    if (track) begin exp_start[idx] = st; exp_len[idx] = ln; end
  endtask

  task automatic run_page(input int sel, input int mode, input bit flip, input bit wr_busy);
    int st, ln, got, last_cyc, done_cyc;
    bit bad, hold, rd_seen, err_seen, busy_at_done;
    logic [DW-1:0] held;
    st = exp_start[sel]; ln = exp_len[sel];
    bad = (ln == 0) || (st + ln > MEMW);
    @(negedge clk); oe = 1'b0; out_ready = 1'b0;
    @(negedge clk); page_sel = 3'(sel); oe = 1'b1;
    got = 0; last_cyc = -10; done_cyc = -1; hold = 0; rd_seen = 0; err_seen = 0;
    busy_at_done = 1; held = '0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      desc_we = 1'b0;
      if (flip && cyc == 3) page_sel = 3'(sel) ^ 3'b111;
      if (wr_busy && cyc == 4) begin
        desc_we = 1'b1; desc_idx = 3'd3; desc_start = '0; desc_len = (AW+1)'(2);
      end
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = (cyc % 2) != 0;
      endcase
      #1;
      if (mem_rd) rd_seen = 1;
      if (error) err_seen = 1;
      if (hold) check(out_valid && out_data == held, "R6 stall hold", int'(out_data), int'(held));
      hold = 0;
      if (done && done_cyc < 0) begin done_cyc = cyc; busy_at_done = busy; end
      if (out_valid && out_ready) begin
        check(out_data == word_of(st + got), "R1 R2 R4 word", int'(out_data), int'(word_of(st + got)));
        got++; last_cyc = cyc;
      end else if (out_valid) begin
        hold = 1; held = out_data;
      end
      if (done || (bad && err_seen && !busy)) break;
    end
    desc_we = 1'b0;
    if (bad) begin
      check(err_seen, "R8 error raised", int'(err_seen), 1);
      check(got == 0 && !rd_seen, "R8 no reads or words", got + int'(rd_seen), 0);
      check(!busy, "R8 idle after error", int'(busy), 0);
    end else begin
      check(got == ln, "R4 word count", got, ln);
      check(!err_seen, "R8 no error on good page", int'(err_seen), 0);
      check(done_cyc == last_cyc + 1, "R7 done timing", done_cyc, last_cyc + 1);
      check(!busy_at_done, "R7 idle with done", int'(busy_at_done), 0);
      @(negedge clk); #1;
      check(!done, "R7 single pulse", int'(done), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    bit busy_seen, rd_seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid && !busy && !done && !error && !mem_rd, "reset state",
          int'({out_valid, busy, done, error, mem_rd}), 0);

    // R3: oe held low, no cycle
    busy_seen = 0; rd_seen = 0;
    repeat (20) begin
      @(negedge clk); #1;
      if (busy) busy_seen = 1;
      if (mem_rd) rd_seen = 1;
    end
    check(!busy_seen && !rd_seen, "R3 no start while oe low", int'(busy_seen) + int'(rd_seen), 0);

    write_desc(0, 0, 3, 1);
    write_desc(1, 3, 1, 1);
    write_desc(2, 4, 10, 1);
    write_desc(3, 14, 5, 1);
    write_desc(4, 20, 12, 1);
    write_desc(5, 0, 0, 1);
    write_desc(6, 25, 8, 1);
    write_desc(7, 31, 1, 1);

    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 8; s++)
        run_page(s, m, 1'b0, 1'b0);

    // R2: select changes mid-cycle
    run_page(2, 1, 1'b1, 1'b0);
    // R10: write while busy ignored, then idle write accepted
    run_page(2, 0, 1'b0, 1'b1);
    run_page(3, 0, 1'b0, 1'b0);
    write_desc(3, 8, 4, 1);
    run_page(3, 2, 1'b0, 1'b0);

    // R9: abort mid-stream, oe stays high, no restart
    @(negedge clk); oe = 1'b0; out_ready = 1'b1;
    @(negedge clk); page_sel = 3'd4; oe = 1'b1;
    repeat (6) @(negedge clk);
    reconfig = 1'b1;
    @(negedge clk); reconfig = 1'b0; #1;
    check(!busy && !out_valid, "R9 abort clears", int'({busy, out_valid}), 0);
    busy_seen = 0; rd_seen = 0;
    repeat (10) begin
      @(negedge clk); #1;
      if (busy || out_valid) busy_seen = 1;
      if (mem_rd) rd_seen = 1;
    end
    check(!busy_seen && !rd_seen, "R9 no restart without new oe rise",
          int'(busy_seen) + int'(rd_seen), 0);
    run_page(1, 0, 1'b0, 1'b0);
    run_page(0, 2, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule